// File: doc/BRIEF.md
# On-demand DMA request handshake unit

This block sits between an external requesting device and a four-channel DMA controller. The device first asks for the shared data bus. The block grants it with a bus-available output. Exactly two cycles later the block samples a 32-bit transfer command word from the bus, qualified by a transfer strobe. The command is decoded in one of three ways: a request pulse for one of the four channels, a setup load for channel 0's control register, or a rejected setup attempt for another channel.

The block records the channel of the last request it issued. A later strobe that arrives without a bus request repeats that request, with no command phase. A device may also raise bus request and strobe together. When the controller reports that channel 2's control register is programmed, this asks for channel 2 at once, with no bus grant. Only request, setup and error outputs are produced. The transfer datapath and bus-cycle timing belong to other blocks.

Top module: `dreq_handshake`

## Requirements
- R1: When the unit is idle and `bus_req_i` is high (and the channel-2 shortcut of R9 does not apply), `bus_avail_o` is high from the next cycle.
- R2: If `bus_avail_o` first goes high in cycle k, the command word and `xfer_strobe_i` are sampled at the clock edge that ends cycle k+1. Any decoded result appears on the outputs in cycle k+2. Strobes in cycle k are ignored.
- R3: `bus_avail_o` is low again in cycle k+3. Bus requests and strobes in cycles k..k+2 are ignored. If the strobe is low at the sampling edge, nothing is issued.
- R4: A sampled command whose mode bits [3:2] are 00 and whose size bits [6:4] are neither 101 nor 110 is a plain request. It produces a one-cycle pulse on `chan_req_o[id]`, where id is bits [1:0].
- R5: Any other sampled command with id 00 produces a one-cycle `setup_load_o` pulse. In the same cycle `setup_word_o` takes the whole 32-bit word, and it holds that value until the next load.
- R6: Any other sampled command with id not 00 loads nothing and raises `err_o` for one cycle.
- R7: Every issued request stores its channel. While idle, a strobe without bus request re-issues a pulse on the stored channel in the next cycle.
- R8: Such a bare strobe before any request has been stored issues no request and raises `err_o` for one cycle.
- R9: Suppose the unit is idle, `bus_req_i` and `xfer_strobe_i` are high together, and `short_armed_i` is high. Then `chan_req_o[2]` pulses in the next cycle, channel 2 is stored, and no bus grant occurs. With `short_armed_i` low, the same inputs start a normal grant.
- R10: At most one bit of `chan_req_o` is high in any cycle, and a setup load never coincides with a request pulse.
- R11: A synchronous active-low reset clears all outputs, forgets the stored channel and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_i | input | 1 | Device asks for the data bus |
| xfer_strobe_i | input | 1 | Transfer strobe from the device |
| cmd_bus_i | input | 32 | Shared data bus carrying the command word |
| short_armed_i | input | 1 | Channel 2 control register is programmed |
| bus_avail_o | output | 1 | Data bus granted to the device |
| chan_req_o | output | 4 | One-cycle request pulse per channel |
| setup_load_o | output | 1 | One-cycle load strobe for channel 0 setup |
| setup_word_o | output | 32 | Command word captured at the last setup load |
| err_o | output | 1 | One-cycle error flag |

## Verification
Two pairs of functions compete for the same cycle. The first pair is the channel-2 shortcut and the start of a bus grant: both are triggered by `bus_req_i` while idle, and they differ only in the strobe and the armed input. The second pair is a bare-strobe replay and strobes or requests that arrive during a grant window and must be dropped. Directed sequences raise request and strobe together with the armed input both high and low, and they hold request and strobe high through a whole grant. Seeded random stimulus then mixes all of these. A cycle-level model in the bench, derived from the requirements, judges every output in every cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   // command field widths
   localparam int ID_W = 2;
   localparam int MD_W = 2;
   localparam int SZ_W = 3;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_WAIT = 2'd1,
      HS_HOLD = 2'd2
   } hs_state_e;

   typedef enum logic [1:0] {
      CK_REQ    = 2'd0,
      CK_SETUP  = 2'd1,
      CK_REJECT = 2'd2
   } cmd_kind_e;
endpackage

// File: rtl/dreq_hs_fsm.sv
module dreq_hs_fsm
   import dreq_pkg::*;
#(
   parameter int GRANT_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req,
   input  logic strobe,
   input  logic shortcut_ok,
   output logic bus_avail,
   output logic cmd_sample,
   output logic shortcut_fire,
   output logic bare_fire
);
   localparam int CNT_W = (GRANT_LAT > 1) ? $clog2(GRANT_LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRANT_LAT - 1);

   generate
      if (GRANT_LAT < 1) begin : g_bad_lat
         $error("GRANT_LAT must be at least 1");
      end
   endgenerate

   hs_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             idle;
   logic             win;

   assign idle          = (state_q == HS_IDLE);
   assign win           = (state_q == HS_WAIT) && (cnt_q == CNT_LAST);
   assign cmd_sample    = win && strobe;
   assign shortcut_fire = idle && bus_req && strobe && shortcut_ok;
   assign bare_fire     = idle && strobe && !bus_req;
   assign bus_avail     = !idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= HS_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            HS_IDLE: begin
               if (bus_req && !shortcut_fire) begin
                  state_q <= HS_WAIT;
                  cnt_q   <= '0;
               end
            end
            HS_WAIT: begin
               if (win) begin
                  state_q <= HS_HOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            HS_HOLD: state_q <= HS_IDLE;
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && bus_req && !shortcut_fire) |=> bus_avail); // R1
   AST_SAMPLE_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sample |-> bus_avail); // R2
   AST_RELEASE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      win |=> (bus_avail ##1 !bus_avail)); // R3
   AST_SHORTCUT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      shortcut_fire |=> !bus_avail); // R9
endmodule

// File: rtl/dreq_cmd_decode.sv
module dreq_cmd_decode
   import dreq_pkg::*;
#(
   parameter int SETUP_CH = 0
) (
   input  logic [ID_W-1:0] id_i,
   input  logic [MD_W-1:0] md_i,
   input  logic [SZ_W-1:0] sz_i,
   output cmd_kind_e       kind_o
);
   localparam logic [SZ_W-1:0] SZ_BAD_A = SZ_W'(5);
   localparam logic [SZ_W-1:0] SZ_BAD_B = SZ_W'(6);

   logic plain;

   assign plain = (md_i == '0) && (sz_i != SZ_BAD_A) && (sz_i != SZ_BAD_B);

   always_comb begin
      if (plain) begin
         kind_o = CK_REQ;
      end else if (id_i == ID_W'(SETUP_CH)) begin
         kind_o = CK_SETUP;
      end else begin
         kind_o = CK_REJECT;
      end
   end
endmodule

// File: rtl/dreq_last_chan.sv
module dreq_last_chan
   import dreq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_ch,
   output logic [ID_W-1:0] last_ch,
   output logic            last_vld
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_ch  <= '0;
         last_vld <= 1'b0;
      end else if (wr_en) begin
         last_ch  <= wr_ch;
         last_vld <= 1'b1;
      end
   end

   AST_STORE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (last_vld && last_ch == $past(wr_ch))); // R7
endmodule

// File: rtl/dreq_handshake.sv
module dreq_handshake
   import dreq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_CH    = 4,
   parameter int GRANT_LAT = 2,
   parameter int ID_LSB    = 0,
   parameter int MD_LSB    = 2,
   parameter int SZ_LSB    = 4,
   parameter int SETUP_CH  = 0,
   parameter int SHORT_CH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req_i,
   input  logic              xfer_strobe_i,
   input  logic [DATA_W-1:0] cmd_bus_i,
   input  logic              short_armed_i,
   output logic              bus_avail_o,
   output logic [NUM_CH-1:0] chan_req_o,
   output logic              setup_load_o,
   output logic [DATA_W-1:0] setup_word_o,
   output logic              err_o
);
   generate
      if (NUM_CH != (1 << ID_W)) begin : g_bad_ch
         $error("NUM_CH must match the channel id field");
      end
      if (SZ_LSB + SZ_W > DATA_W || MD_LSB + MD_W > DATA_W || ID_LSB + ID_W > DATA_W) begin : g_bad_field
         $error("command fields exceed the data bus");
      end
      if (SHORT_CH >= NUM_CH || SETUP_CH >= NUM_CH) begin : g_bad_sel
         $error("channel selection out of range");
      end
   endgenerate

   logic            cmd_sample;
   logic            shortcut_fire;
   logic            bare_fire;
   cmd_kind_e       dec_kind;
   logic [ID_W-1:0] dec_id;
   logic [ID_W-1:0] last_ch;
   logic            last_vld;
   logic            fire;
   logic [ID_W-1:0] fire_ch;
   logic            setup_hit;
   logic            err_hit;

   assign dec_id = cmd_bus_i[ID_LSB +: ID_W];

   dreq_hs_fsm #(.GRANT_LAT(GRANT_LAT)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_req      (bus_req_i),
      .strobe       (xfer_strobe_i),
      .shortcut_ok  (short_armed_i),
      .bus_avail    (bus_avail_o),
      .cmd_sample   (cmd_sample),
      .shortcut_fire(shortcut_fire),
      .bare_fire    (bare_fire)
   );

   dreq_cmd_decode #(.SETUP_CH(SETUP_CH)) u_dec (
      .id_i  (dec_id),
      .md_i  (cmd_bus_i[MD_LSB +: MD_W]),
      .sz_i  (cmd_bus_i[SZ_LSB +: SZ_W]),
      .kind_o(dec_kind)
   );

   // request source: shortcut, decoded command, or replay (exclusive by state)
   always_comb begin
      fire    = 1'b0;
      fire_ch = '0;
      if (shortcut_fire) begin
         fire    = 1'b1;
         fire_ch = ID_W'(SHORT_CH);
      end else if (cmd_sample && dec_kind == CK_REQ) begin
         fire    = 1'b1;
         fire_ch = dec_id;
      end else if (bare_fire && last_vld) begin
         fire    = 1'b1;
         fire_ch = last_ch;
      end
   end

   assign setup_hit = cmd_sample && (dec_kind == CK_SETUP);
   assign err_hit   = (cmd_sample && dec_kind == CK_REJECT) || (bare_fire && !last_vld);

   dreq_last_chan u_last (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fire),
      .wr_ch   (fire_ch),
      .last_ch (last_ch),
      .last_vld(last_vld)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_req
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chan_req_o[g] <= 1'b0;
            end else begin
               chan_req_o[g] <= fire && (fire_ch == ID_W'(g));
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         setup_load_o <= 1'b0;
         setup_word_o <= '0;
         err_o        <= 1'b0;
      end else begin
         setup_load_o <= setup_hit;
         err_o        <= err_hit;
         if (setup_hit) begin
            setup_word_o <= cmd_bus_i;
         end
      end
   end

   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_req_o)); // R10
   AST_LOAD_NOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      setup_load_o |-> (chan_req_o == '0)); // R10
   AST_EMPTY_REPLAY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bare_fire && !last_vld) |=> (err_o && chan_req_o == '0)); // R8
   AST_SHORTCUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      shortcut_fire |=> chan_req_o[SHORT_CH]); // R9
   AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      setup_hit |=> (setup_load_o && setup_word_o == $past(cmd_bus_i))); // R5
endmodule

// File: tb/sim_dreq_handshake.sv
module sim_dreq_handshake;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_req_i, xfer_strobe_i, short_armed_i;
   logic [31:0] cmd_bus_i;
   logic        bus_avail_o, setup_load_o, err_o;
   logic [3:0]  chan_req_o;
   logic [31:0] setup_word_o;

   always #2 clk = ~clk;

   dreq_handshake u0 (
      .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .xfer_strobe_i(xfer_strobe_i),
      .cmd_bus_i(cmd_bus_i), .short_armed_i(short_armed_i), .bus_avail_o(bus_avail_o),
      .chan_req_o(chan_req_o), .setup_load_o(setup_load_o), .setup_word_o(setup_word_o),
      .err_o(err_o)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   int          ms = 0, mc = 0, mlast = 0;
   bit          mlv = 0;
   bit          e_avail = 0, e_load = 0, e_err = 0;
   logic [3:0]  e_req = '0;
   logic [31:0] e_word = '0;
   string       lbl = "R11 reset";

   function automatic bit is_plain(logic [31:0] w);
      return (w[3:2] == 2'b00) && (w[6:4] != 3'b101) && (w[6:4] != 3'b110);
   endfunction

   task automatic model_reset();
      ms = 0; mc = 0; mlast = 0; mlv = 0;
      e_avail = 0; e_load = 0; e_err = 0; e_req = '0; e_word = '0;
   endtask

   task automatic model_step(bit br, bit st, bit arm, logic [31:0] w);
      e_req = '0; e_load = 0; e_err = 0;
      case (ms)
         0: begin
            if (br && st && arm) begin
               e_req[2] = 1; mlast = 2; mlv = 1;
            end else if (br) begin
               ms = 1; mc = 0;
            end else if (st) begin
               if (mlv) e_req[mlast] = 1; else e_err = 1;
            end
         end
         1: begin
            if (mc == 1) begin
               ms = 2;
               if (st) begin
                  if (is_plain(w)) begin
                     e_req[w[1:0]] = 1; mlast = int'(w[1:0]); mlv = 1;
                  end else if (w[1:0] == 2'b00) begin
                     e_load = 1; e_word = w;
                  end else begin
                     e_err = 1;
                  end
               end
            end else begin
               mc++;
            end
         end
         default: ms = 0;
      endcase
      e_avail = (ms != 0);
   endtask

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", lbl, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("bus_avail", 32'(bus_avail_o), 32'(e_avail));
      chk("chan_req", 32'(chan_req_o), 32'(e_req));
      chk("setup_load", 32'(setup_load_o), 32'(e_load));
      chk("setup_word", setup_word_o, e_word);
      chk("err", 32'(err_o), 32'(e_err));
   endtask

   // one cycle: judge outputs from the previous edge, then apply new stimulus
   task automatic cyc(bit br, bit st, bit arm, logic [31:0] w, string l);
      @(negedge clk);
      compare_all();
      bus_req_i = br; xfer_strobe_i = st; short_armed_i = arm; cmd_bus_i = w;
      model_step(br, st, arm, w);
      lbl = l;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; bus_req_i = 0; xfer_strobe_i = 0; short_armed_i = 0; cmd_bus_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      lbl = "R11 reset";
      compare_all();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0;
      do_reset();
      // R8: bare strobe with nothing stored
      cyc(0, 1, 0, '0, "R8 empty replay");
      cyc(0, 0, 0, '0, "R8 idle");
      // R1 R2 R4: grant then plain request for channel 3
      cyc(1, 0, 0, '0, "R1 grant");
      cyc(0, 1, 0, 32'hFFFF_FF03 & ~32'h7C, "R2 early strobe ignored");
      cyc(0, 1, 0, 32'h0000_0003, "R4 plain ch3");
      cyc(0, 0, 0, '0, "R3 hold");
      cyc(0, 0, 0, '0, "R3 released");
      // R7: replay of channel 3
      cyc(0, 1, 0, '0, "R7 replay");
      cyc(0, 1, 0, '0, "R7 replay again");
      cyc(0, 0, 0, '0, "R7 idle");
      // R5: setup loads (mode nonzero; mode zero with size 101)
      cyc(1, 0, 0, '0, "R5 grant");
      cyc(0, 0, 0, '0, "R5 wait");
      cyc(0, 1, 0, 32'hA5C3_1E04, "R5 setup md01");
      cyc(0, 0, 0, '0, "R5 hold");
      cyc(1, 0, 0, '0, "R5 grant b");
      cyc(0, 0, 0, '0, "R5 wait b");
      cyc(0, 1, 0, 32'h1234_0050, "R5 setup sz101");
      cyc(0, 0, 0, '0, "R5 hold b");
      // R6: setup attempt for channel 1
      cyc(1, 0, 0, '0, "R6 grant");
      cyc(0, 0, 0, '0, "R6 wait");
      cyc(0, 1, 0, 32'hDEAD_0069, "R6 reject ch1");
      cyc(0, 0, 0, '0, "R6 hold");
      // R3: request and strobe held through the grant, strobe low at sample
      cyc(1, 0, 0, '0, "R3 grant");
      cyc(1, 1, 1, '0, "R3 req ignored");
      cyc(1, 0, 0, 32'h0000_0001, "R3 no strobe at sample");
      cyc(1, 1, 1, '0, "R3 hold ignores");
      cyc(0, 0, 0, '0, "R3 idle");
      // R9: shortcut armed and not armed
      cyc(1, 1, 1, '0, "R9 shortcut");
      cyc(0, 1, 0, '0, "R9 replay stored ch2");
      cyc(1, 1, 0, '0, "R9 unarmed grants");
      cyc(0, 0, 0, '0, "R9 wait");
      cyc(0, 1, 0, 32'h0000_0001, "R9 plain ch1");
      cyc(0, 0, 0, '0, "R9 hold");
      cyc(0, 0, 0, '0, "R9 idle");
      // R11: reset forgets stored channel
      do_reset();
      cyc(0, 1, 0, '0, "R11 R8 replay after reset");
      cyc(0, 0, 0, '0, "R11 idle");
      // R10: seeded random mix
      for (int i = 0; i < 4000; i++) begin
         bit br, st, arm;
         logic [31:0] w;
         br  = ($urandom % 100) < 30;
         st  = ($urandom % 100) < 40;
         arm = ($urandom % 100) < 50;
         w   = $urandom;
         if (($urandom % 2) == 0) w[3:2] = 2'b00;
         cyc(br, st, arm, w, "R10 random");
      end
      cyc(0, 0, 0, '0, "R10 tail");
      @(negedge clk);
      compare_all();
      finish_run();
   end
endmodule